// File: doc/BRIEF.md
# Synchronous Burst SRAM with Linear and Interleaved Address Sequencing

This block is a clocked single-port memory for a processor or cache controller that fetches short bursts of up to four words. A burst opens when either of two address strobes is seen at a rising clock edge. The processor strobe counts only while the primary chip enable is active. The controller strobe always counts. When a burst opens, the block captures the address and the mode pin. After that, a 2-bit counter produces the low two address bits of the following words. It steps once on every edge where the advance input is high. The counter runs in wrap-around order (add modulo 4) or in exclusive-or order, as the captured mode bit selects.

Reads are flow-through. The word at the current address goes straight to the data bus, so the first word costs the edge that takes the address plus one more. Each later word costs one edge (2-1-1-1).

Writes use late data. The write enables and data sampled at an edge go to the address that was current before that edge. A global write stores every byte lane. Otherwise the byte-write enable and the per-lane enables choose the lanes. The data bus is modelled as an output word with a separate drive-enable. The drive-enable is high only while a burst is selected, the last edge sampled no write, output enable is high and sleep is low. Output enable and sleep act on it without waiting for a clock. While sleep is high, all clocked inputs are ignored. After sleep falls, the block is deselected.

The controller states are DESEL (no burst; the bus is never driven), BURST (a burst address is valid) and SLEEP (entered on any edge with sleep high). The transitions are:
- DESEL to BURST, and SLEEP to BURST: an accepted strobe with all three enables active.
- BURST to BURST: a restart, a step or a hold.
- BURST to DESEL: an accepted strobe with any enable inactive.
- Any state to SLEEP: sleep high at the edge.
- SLEEP to DESEL: sleep low and no qualified start.

Top module: `burst_sram`

## Requirements
- R1: After reset the block is in DESEL, `dq_oe` is 0 and every memory word reads as zero.
- R2: An edge with `strb_ctl` high, or with `strb_cpu` and `en_a` both high, is an accepted strobe. An accepted strobe with `en_a`, `en_b` and `en_c` all high captures `addr` and `mode_intlv`, restarts the count at 0 and selects the block. An accepted strobe with any enable low deselects the block. `strb_cpu` with `en_a` low and `strb_ctl` low changes nothing.
- R3: With the captured mode bit at 0, the word at count n has low bits (first + n) mod 4. The upper address bits stay as captured. For example, a start of 1 gives 1,2,3,0.
- R4: With the captured mode bit at 1, the word at count n has low bits first XOR n. For example, a start of 1 gives 1,0,3,2 and a start of 2 gives 2,3,0,1.
- R5: The count steps only on edges with `adv` high, the block selected and no accepted strobe. It holds otherwise, and it wraps from 3 to 0.
- R6: In the cycle after an accepted, enabled strobe edge without write, `dq_out` already shows the word at the captured address (flow-through, no extra output register).
- R7: With `gw` low and `bwe` high, only lanes whose `be` bit is 1 are written. Bit i of `be` guards `wdata[8i+7:8i]`.
- R8: With `gw` high, all lanes are written whatever `bwe` and `be` are.
- R9: With `gw` and `bwe` both low, nothing is written whatever `be` is, and the edge counts as a read.
- R10: `dq_oe` is high exactly when the block is selected, the last edge sampled no write, `oe` is high and `sleep` is low. `oe` takes effect without a clock edge.
- R11: While `sleep` is high, `dq_oe` is 0 at once and strobes, writes and advance are ignored. After `sleep` falls, the block is deselected.
- R12: Write enables sampled while the block is deselected change no memory word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | AW | Word address taken on an accepted strobe |
| wdata | input | 8*NB | Write data sampled at each edge |
| en_a | input | 1 | Primary chip enable, active high; also qualifies the processor strobe |
| en_b | input | 1 | Second chip enable, active high |
| en_c | input | 1 | Third chip enable, active high |
| strb_cpu | input | 1 | Processor address strobe, active high |
| strb_ctl | input | 1 | Controller address strobe, active high |
| adv | input | 1 | Step the burst count |
| mode_intlv | input | 1 | 1 selects XOR order, 0 selects wrap-around order; taken at burst start |
| gw | input | 1 | Global write, all lanes |
| bwe | input | 1 | Byte-write enable |
| be | input | NB | Per-lane write enables |
| oe | input | 1 | Output enable, asynchronous |
| sleep | input | 1 | Sleep request, asynchronous; assert only while deselected |
| dq_out | output | 8*NB | Flow-through read data |
| dq_oe | output | 1 | Bus drive enable; 0 means high impedance |

## Verification
The hardest state to reach is the mix of a running burst with strobes that must not interrupt it. Examples are a processor strobe with the primary enable low arriving in the middle of a burst, and a strobe arriving while sleep is high. Both are hard because the effect is only visible on a later read address. The stimulus fills the memory with distinct words and starts bursts from several low-bit offsets in both orders. It then injects these strobes between advance beats, so any wrong capture shows up as a wrong word on the next compared cycle. Output enable and sleep are changed a quarter period after an edge, so their effect is seen with no clock edge in between.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

    typedef enum logic [1:0] {
        ST_DESEL = 2'd0,
        ST_BURST = 2'd1,
        ST_SLEEP = 2'd2
    } bst_state_e;

    // Low two address bits of the word at position n of a burst.
    function automatic logic [1:0] burst_low(
        input logic [1:0] first,
        input logic [1:0] n,
        input logic       intlv
    );
        logic [1:0] r;
        if (intlv) r = first ^ n;
        else       r = first + n;
        return r;
    endfunction

endpackage

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
    import burst_sram_pkg::*;
#(
    parameter int NB = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sleep,
    input  logic          strb_cpu,
    input  logic          strb_ctl,
    input  logic          en_a,
    input  logic          en_b,
    input  logic          en_c,
    input  logic          adv,
    input  logic          gw,
    input  logic          bwe,
    input  logic [NB-1:0] be,
    input  logic          oe,
    output logic          load,
    output logic          step,
    output logic [NB-1:0] wr_mask,
    output logic          sel,
    output logic          bus_en
);

    bst_state_e    state, nxt;
    logic          start;
    logic          en_all;
    logic [NB-1:0] mask_raw;
    logic          rd_q;

    assign start    = strb_ctl | (strb_cpu & en_a);
    assign en_all   = en_a & en_b & en_c;
    assign mask_raw = gw ? {NB{1'b1}} : (bwe ? be : '0);

    // Next-state logic
    always_comb begin
        nxt = ST_DESEL;
        if (sleep) begin
            nxt = ST_SLEEP;
        end else begin
            unique case (state)
                ST_DESEL, ST_SLEEP: nxt = (start && en_all) ? ST_BURST : ST_DESEL;
                ST_BURST:           nxt = (start && !en_all) ? ST_DESEL : ST_BURST;
                default:            nxt = ST_DESEL;
            endcase
        end
    end

    // State register and read/write flag of the last edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_DESEL;
            rd_q  <= 1'b1;
        end else begin
            state <= nxt;
            if (!sleep) rd_q <= ~|mask_raw;
        end
    end

    // Outputs
    always_comb begin
        sel     = (state == ST_BURST);
        load    = !sleep && start && en_all;
        step    = !sleep && sel && !start && adv;
        wr_mask = (!sleep && sel) ? mask_raw : '0;
        bus_en  = sel && rd_q && oe && !sleep;
    end

endmodule

// File: rtl/burst_sram_seq.sv
module burst_sram_seq
    import burst_sram_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] addr_in,
    input  logic          mode_in,
    output logic [AW-1:0] cur_addr
);

    localparam int HW = AW - 2;

    logic [HW-1:0] hi_q;
    logic [1:0]    first_q;
    logic [1:0]    cnt_q;
    logic          intlv_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q    <= '0;
            first_q <= '0;
            cnt_q   <= '0;
            intlv_q <= 1'b0;
        end else if (load) begin
            hi_q    <= addr_in[AW-1:2];
            first_q <= addr_in[1:0];
            cnt_q   <= '0;
            intlv_q <= mode_in;
        end else if (step) begin
            cnt_q   <= cnt_q + 2'd1;
        end
    end

    assign cur_addr = {hi_q, burst_low(first_q, cnt_q, intlv_q)};

endmodule

// File: rtl/burst_sram_array.sv
module burst_sram_array #(
    parameter int AW = 4,
    parameter int NB = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   addr,
    input  logic [NB*8-1:0] wdata,
    input  logic [NB-1:0]   wr_mask,
    output logic [NB*8-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < NB; g++) begin : g_lane
        logic [7:0] lane_mem [DEPTH];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int d = 0; d < DEPTH; d++) lane_mem[d] <= '0;
            end else if (wr_mask[g]) begin
                lane_mem[addr] <= wdata[g*8 +: 8];
            end
        end

        assign rdata[g*8 +: 8] = lane_mem[addr];
    end

endmodule

// File: rtl/burst_sram.sv
module burst_sram
    import burst_sram_pkg::*;
#(
    parameter int AW = 4,
    parameter int NB = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   addr,
    input  logic [NB*8-1:0] wdata,
    input  logic            en_a,
    input  logic            en_b,
    input  logic            en_c,
    input  logic            strb_cpu,
    input  logic            strb_ctl,
    input  logic            adv,
    input  logic            mode_intlv,
    input  logic            gw,
    input  logic            bwe,
    input  logic [NB-1:0]   be,
    input  logic            oe,
    input  logic            sleep,
    output logic [NB*8-1:0] dq_out,
    output logic            dq_oe
);

    logic          load;
    logic          step;
    logic          sel;
    logic [NB-1:0] wr_mask;
    logic [AW-1:0] cur_addr;

    burst_sram_ctrl #(.NB(NB)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .sleep(sleep),
        .strb_cpu(strb_cpu), .strb_ctl(strb_ctl),
        .en_a(en_a), .en_b(en_b), .en_c(en_c),
        .adv(adv), .gw(gw), .bwe(bwe), .be(be), .oe(oe),
        .load(load), .step(step), .wr_mask(wr_mask),
        .sel(sel), .bus_en(dq_oe)
    );

    burst_sram_seq #(.AW(AW)) u_seq (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step),
        .addr_in(addr), .mode_in(mode_intlv), .cur_addr(cur_addr)
    );

    burst_sram_array #(.AW(AW), .NB(NB)) u_array (
        .clk(clk), .rst_n(rst_n), .addr(cur_addr),
        .wdata(wdata), .wr_mask(wr_mask), .rdata(dq_out)
    );

endmodule

// File: rtl/burst_sram_checker.sv
module burst_sram_checker #(
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sleep,
    input logic          oe,
    input logic          en_a,
    input logic          strb_cpu,
    input logic          strb_ctl,
    input logic          adv,
    input logic          gw,
    input logic          dq_oe,
    input logic          sel,
    input logic [AW-1:0] cur_addr
);

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !dq_oe);

    assert_cpu_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel && strb_cpu && !en_a && !strb_ctl) |=> !sel);

    assert_ctl_deselect_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_ctl && !en_a) |=> !sel);

    assert_hold_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !adv && !strb_cpu && !strb_ctl && !sleep) |=> $stable(cur_addr));

    assert_write_no_drive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && gw && !sleep) |=> !dq_oe);

    assert_oe_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> !dq_oe);

    assert_sleep_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !dq_oe);

endmodule

bind burst_sram burst_sram_checker #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .oe(oe), .en_a(en_a),
    .strb_cpu(strb_cpu), .strb_ctl(strb_ctl), .adv(adv), .gw(gw),
    .dq_oe(dq_oe), .sel(sel), .cur_addr(cur_addr)
);

// File: tb/burst_sram_bench.sv
module burst_sram_bench;

    localparam int CLK_P = 10;
    localparam int AW    = 4;
    localparam int NB    = 4;
    localparam int DW    = NB * 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          en_a = 1'b0, en_b = 1'b0, en_c = 1'b0;
    logic          strb_cpu = 1'b0, strb_ctl = 1'b0, adv = 1'b0;
    logic          mode_intlv = 1'b0, gw = 1'b0, bwe = 1'b0;
    logic [NB-1:0] be = '0;
    logic          oe = 1'b1, sleep = 1'b0;
    logic [DW-1:0] dq_out;
    logic          dq_oe;

    int    vectors = 0;
    int    fails   = 0;
    string cur_req = "R1";
    bit    done    = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    burst_sram #(.AW(AW), .NB(NB)) u_burst_sram (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .en_a(en_a), .en_b(en_b), .en_c(en_c),
        .strb_cpu(strb_cpu), .strb_ctl(strb_ctl), .adv(adv),
        .mode_intlv(mode_intlv), .gw(gw), .bwe(bwe), .be(be),
        .oe(oe), .sleep(sleep), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    // Behavioural reference
    logic [DW-1:0] m_mem [DEPTH];
    bit  m_sel, m_rd, m_int, m_live;
    int  m_base, m_cnt;

    function automatic int m_addr();
        int lo;
        lo = m_int ? ((m_base % 4) ^ m_cnt) : (((m_base % 4) + m_cnt) % 4);
        return (m_base / 4) * 4 + lo;
    endfunction

    always @(posedge clk) begin
        logic [NB-1:0] mask;
        bit st;
        if (!rst_n) begin
            m_sel = 0; m_rd = 1; m_base = 0; m_cnt = 0; m_int = 0; m_live = 1;
            for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
        end else if (sleep) begin
            m_sel = 0;
        end else begin
            mask = gw ? {NB{1'b1}} : (bwe ? be : '0);
            if (m_sel) begin
                for (int b = 0; b < NB; b++)
                    if (mask[b]) m_mem[m_addr()][b*8 +: 8] = wdata[b*8 +: 8];
            end
            st = strb_ctl || (strb_cpu && en_a);
            if (st) begin
                if (en_a && en_b && en_c) begin
                    m_sel = 1; m_base = int'(addr); m_int = mode_intlv; m_cnt = 0;
                end else begin
                    m_sel = 0;
                end
            end else if (m_sel && adv) begin
                m_cnt = (m_cnt + 1) % 4;
            end
            m_rd = (mask == '0);
        end
    end

    always @(negedge clk) begin
        bit exp_oe;
        if (m_live && !done) begin
            exp_oe = m_sel && m_rd && oe && !sleep;
            vectors++;
            if (dq_oe !== exp_oe) begin
                fails++;
                $display("FAIL %s dq_oe actual %0b expected %0b at %0t", cur_req, dq_oe, exp_oe, $time);
            end else if (exp_oe && dq_out !== m_mem[m_addr()]) begin
                fails++;
                $display("FAIL %s dq_out actual %h expected %h at %0t", cur_req, dq_out, m_mem[m_addr()], $time);
            end
        end
    end

    task automatic cyc();
        @(posedge clk);
        #(CLK_P/4);
    endtask

    task automatic begin_burst(input bit cpu, input int a, input bit intlv);
        addr = AW'(a); mode_intlv = intlv;
        en_a = 1; en_b = 1; en_c = 1;
        if (cpu) strb_cpu = 1; else strb_ctl = 1;
        cyc();
        strb_cpu = 0; strb_ctl = 0;
    endtask

    task automatic beat(input bit a, input bit g, input bit bw, input logic [NB-1:0] b, input logic [DW-1:0] d);
        adv = a; gw = g; bwe = bw; be = b; wdata = d;
        cyc();
        adv = 0; gw = 0; bwe = 0; be = '0;
    endtask

    task automatic deselect();
        en_a = 0; strb_ctl = 1;
        cyc();
        strb_ctl = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL %s watchdog actual timeout expected finish", cur_req);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        cur_req = "R1";
        repeat (3) cyc();
        rst_n = 1;
        cyc(); cyc();
        // Reset contents read as zero
        begin_burst(0, 5, 0);
        beat(1, 0, 0, '0, '0); beat(1, 0, 0, '0, '0);
        deselect();

        cur_req = "R8";
        for (int a = 0; a < DEPTH; a += 4) begin
            begin_burst(0, a, 0);
            for (int k = 0; k < 4; k++)
                beat(1, 1, 0, '0, 32'hA500_0000 ^ (32'h0101_0101 * (a + k + 1)));
        end
        deselect();

        cur_req = "R3";
        begin_burst(1, 1, 0);
        repeat (5) beat(1, 0, 0, '0, '0);
        begin_burst(0, 14, 0);
        repeat (4) beat(1, 0, 0, '0, '0);

        cur_req = "R4";
        begin_burst(1, 1, 1);
        repeat (5) beat(1, 0, 0, '0, '0);
        begin_burst(0, 6, 1);
        repeat (4) beat(1, 0, 0, '0, '0);
        begin_burst(0, 11, 1);
        repeat (4) beat(1, 0, 0, '0, '0);

        cur_req = "R6";
        begin_burst(0, 9, 0);
        begin_burst(1, 3, 1);

        cur_req = "R5";
        begin_burst(0, 4, 0);
        repeat (3) beat(0, 0, 0, '0, '0);
        beat(1, 0, 0, '0, '0);
        repeat (2) beat(0, 0, 0, '0, '0);
        repeat (7) beat(1, 0, 0, '0, '0);

        cur_req = "R2";
        begin_burst(0, 8, 0);
        beat(1, 0, 0, '0, '0);
        en_a = 0; strb_cpu = 1; addr = 4'd2; adv = 1;
        cyc();
        strb_cpu = 0; adv = 0; en_a = 1;
        repeat (2) beat(1, 0, 0, '0, '0);
        en_b = 0; strb_ctl = 1;
        cyc();
        strb_ctl = 0; en_b = 1;
        beat(1, 0, 0, '0, '0);
        en_a = 0; strb_cpu = 1; addr = 4'd0;
        cyc();
        strb_cpu = 0; en_a = 1;
        beat(0, 0, 0, '0, '0);

        cur_req = "R7";
        begin_burst(0, 12, 0);
        beat(1, 0, 1, 4'b0101, 32'h1122_3344);
        beat(1, 0, 1, 4'b1000, 32'h5566_7788);
        beat(0, 0, 0, '0, '0);
        begin_burst(0, 12, 0);
        repeat (3) beat(1, 0, 0, '0, '0);

        cur_req = "R9";
        begin_burst(0, 2, 0);
        beat(1, 0, 0, 4'b1111, 32'hDEAD_BEEF);
        beat(1, 0, 0, 4'b0011, 32'hCAFE_F00D);
        begin_burst(0, 2, 0);
        repeat (3) beat(1, 0, 0, '0, '0);

        cur_req = "R10";
        begin_burst(1, 7, 1);
        oe = 0;
        #(CLK_P/2);
        oe = 1;
        beat(1, 0, 0, '0, '0);
        oe = 0;
        beat(1, 0, 0, '0, '0);
        oe = 1;
        beat(1, 1, 0, '0, 32'h0BAD_0BAD);
        beat(1, 0, 0, '0, '0);

        cur_req = "R12";
        deselect();
        beat(1, 1, 0, '0, 32'hFFFF_0000);
        beat(0, 0, 1, 4'b1111, 32'h0000_FFFF);
        begin_burst(0, 7, 0);
        beat(0, 0, 0, '0, '0);

        cur_req = "R11";
        begin_burst(0, 0, 0);
        deselect();
        sleep = 1;
        cyc();
        begin_burst(0, 4, 0);
        beat(1, 1, 0, '0, 32'h7777_7777);
        sleep = 0;
        cyc(); cyc();
        begin_burst(0, 4, 0);
        repeat (3) beat(1, 0, 0, '0, '0);
        begin_burst(0, 3, 1);
        sleep = 1;
        #(CLK_P/2);
        sleep = 0;
        deselect();
        cyc();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule